// File: doc/BRIEF.md
# I2C SCL Rate Generator

This block turns a fast input clock into the serial-clock timing for an I2C master. Two divisor fields come from a 16-bit control word. The small divisor prescales the input clock. The large divisor divides the prescaled enable again to make one tick. Twenty-two ticks form one SCL period, so the SCL frequency is the input clock divided by 22 × (A+1) × (B+1). With the default widths, the product of the two divisors can reach 256 at most.

While `enable` is low the generator is idle. In that state it releases SCL high and keeps reading the divisor fields. When `enable` rises, the fields are frozen. The frame then starts with SCL low for eleven ticks, followed by SCL high for eleven ticks, and this repeats. A bit engine consumes four one-cycle strobes: SCL has risen, SCL has fallen, the midpoint of the low phase (the point to drive SDA), and the midpoint of the high phase (the point to sample SDA).

The frame sequencer is a state machine with three states:
- ST_IDLE: SCL is released.
- ST_LOW: SCL is driven low.
- ST_HIGH: SCL is released during a frame.

Its transitions are:
- start: ST_IDLE to ST_LOW, when `enable` is seen high.
- rise: ST_LOW to ST_HIGH, on the tick that ends tick slot 10.
- fall: ST_HIGH to ST_LOW, on the tick that ends tick slot 21.
- stop: ST_LOW or ST_HIGH to ST_IDLE, whenever `enable` is low.

Top module: `scl_rate_gen`

## Requirements
- R1: While idle, both after reset and after `enable` has been seen low, `scl_level` is 1 and all four strobes are 0.
- R2: The first stage divides the input clock by A+1, where A = `ctrl_word[15:14]`.
- R3: The second stage divides the first stage's pulses by B+1, where B = `ctrl_word[13:8]`. One tick therefore lasts P = (A+1)(B+1) input cycles.
- R4: Count k from 0, where k = 0 is the first cycle after the edge that sees `enable` high. Tick slot n covers cycles nP to nP+P-1. `scl_level` is 0 for slots 0 to 10 and 1 for slots 11 to 21, repeating every 22P cycles.
- R5: `rise_stb` is high for exactly the first cycle of slot 11 in each frame.
- R6: `fall_stb` is high for exactly the first cycle of slot 0 in every frame after the first. It is not raised when the generator starts.
- R7: `drive_stb` is high in the first cycle of slot 5. `sample_stb` is high in the first cycle of slot 16.
- R8: The divisors are captured at the edge that starts the generator. Changes to `ctrl_word` while it runs have no effect.
- R9: One cycle after `enable` is seen low, SCL is released. The next start begins again at slot 0 with freshly captured divisors.
- R10: At most one strobe is high in any cycle.
- R11: `ctrl_word[7:0]` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the frame while high |
| ctrl_word | input | 16 | Control word: bits 15:14 hold A, bits 13:8 hold B, bits 7:0 are ignored |
| scl_level | output | 1 | SCL request: 0 = drive low, 1 = release |
| rise_stb | output | 1 | SCL has gone high |
| sample_stb | output | 1 | Midpoint of the high phase |
| fall_stb | output | 1 | SCL has gone low |
| drive_stb | output | 1 | Midpoint of the low phase |

## Verification
The hardest situation to reach from the ports is a change of the control word in the middle of a frame. It is only visible as the absence of a change in timing, many cycles later. The bench starts a slow frame, rewrites the divisor fields a few slot boundaries in, and then compares every following cycle against the timing of the original divisors. It also stops the generator mid-frame and restarts it with different divisors. That run shows the counters are cleared rather than resumed from their old state.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } scl_state_e;
endpackage

// File: rtl/scl_div_stage.sv
// One down-counting divider stage: reloads on wrap, emits one pulse per wrap.
module scl_div_stage #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         step,
    input  logic [W-1:0] reload_val,
    output logic         wrap
);
    logic [W-1:0] cnt_q;

    assign wrap = run && step && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= reload_val;
        end else if (step) begin
            if (cnt_q == '0) cnt_q <= reload_val;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    // R2 / R3: a running count never exceeds the frozen divisor
    a_r3_cnt_within_reload: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= reload_val));
endmodule

// File: rtl/scl_frame_fsm.sv
// Sequences the tick slots of one SCL frame and produces the phase strobes.
module scl_frame_fsm
    import scl_gen_pkg::*;
#(
    parameter int FRAME_TICKS = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    output logic running,
    output logic scl_level,
    output logic rise_stb,
    output logic sample_stb,
    output logic fall_stb,
    output logic drive_stb
);
    localparam int PH_W      = $clog2(FRAME_TICKS);
    localparam int HALF      = FRAME_TICKS / 2;
    localparam logic [PH_W-1:0] LAST_PH   = PH_W'(FRAME_TICKS - 1);
    localparam logic [PH_W-1:0] LOW_END   = PH_W'(HALF - 1);
    localparam logic [PH_W-1:0] HIGH_AT   = PH_W'(HALF);
    localparam logic [PH_W-1:0] PRE_DRIVE = PH_W'(HALF / 2 - 1);
    localparam logic [PH_W-1:0] PRE_SAMP  = PH_W'(HALF + HALF / 2 - 1);

    scl_state_e      state_q, state_d;
    logic [PH_W-1:0] phase_q, phase_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        unique case (state_q)
            ST_IDLE: begin
                phase_d = '0;
                if (enable) state_d = ST_LOW;        // start
            end
            ST_LOW: begin
                if (!enable) begin
                    state_d = ST_IDLE;               // stop
                    phase_d = '0;
                end else if (tick) begin
                    if (phase_q == LOW_END) state_d = ST_HIGH;  // rise
                    phase_d = phase_q + 1'b1;
                end
            end
            ST_HIGH: begin
                if (!enable) begin
                    state_d = ST_IDLE;               // stop
                    phase_d = '0;
                end else if (tick) begin
                    if (phase_q == LAST_PH) begin
                        state_d = ST_LOW;            // fall
                        phase_d = '0;
                    end else begin
                        phase_d = phase_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                phase_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
        end
    end

    // output register: strobes line up with the slot they announce
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_stb   <= 1'b0;
            fall_stb   <= 1'b0;
            drive_stb  <= 1'b0;
            sample_stb <= 1'b0;
        end else begin
            rise_stb   <= (state_q == ST_LOW)  && (state_d == ST_HIGH);
            fall_stb   <= (state_q == ST_HIGH) && (state_d == ST_LOW);
            drive_stb  <= enable && tick && (state_q == ST_LOW)  && (phase_q == PRE_DRIVE);
            sample_stb <= enable && tick && (state_q == ST_HIGH) && (phase_q == PRE_SAMP);
        end
    end

    assign scl_level = (state_q != ST_LOW);
    assign running   = (state_q != ST_IDLE);

    // R4: the high state only ever covers the second half of the frame
    a_r4_high_in_second_half: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH) |-> (phase_q >= HIGH_AT));
    // R5: a rise strobe coincides with a released line
    a_r5_rise_when_high: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> scl_level);
    // R6: a fall strobe coincides with a driven-low line
    a_r6_fall_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> !scl_level);
    // R7: the drive point sits in the low half, the sample point in the high half
    a_r7_points_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_stb |-> !scl_level) and (sample_stb |-> scl_level));
endmodule

// File: rtl/scl_rate_gen.sv
// Top: freezes the divisors, cascades the two dividers and drives the frame FSM.
module scl_rate_gen
    import scl_gen_pkg::*;
#(
    parameter int A_W         = 2,
    parameter int B_W         = 6,
    parameter int B_LSB       = 8,
    parameter int FRAME_TICKS = 22
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic [15:0] ctrl_word,
    output logic        scl_level,
    output logic        rise_stb,
    output logic        sample_stb,
    output logic        fall_stb,
    output logic        drive_stb
);
    localparam int A_LSB  = B_LSB + B_W;
    localparam int CTRL_W = A_LSB + A_W;

    logic [A_W-1:0] div_a_q, div_a_eff, field_a;
    logic [B_W-1:0] div_b_q, div_b_eff, field_b;
    logic           running, pre_wrap, tick;
    logic           ctrl_unused;

    assign field_a     = ctrl_word[A_LSB +: A_W];
    assign field_b     = ctrl_word[B_LSB +: B_W];
    assign ctrl_unused = ^{ctrl_word[B_LSB-1:0], 1'b0};

    // divisors track the fields while idle and freeze once running
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_a_q <= '0;
            div_b_q <= '0;
        end else if (!running) begin
            div_a_q <= field_a;
            div_b_q <= field_b;
        end
    end

    assign div_a_eff = running ? div_a_q : field_a;
    assign div_b_eff = running ? div_b_q : field_b;

    scl_div_stage #(.W(A_W)) u_prescale (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (running),
        .step       (1'b1),
        .reload_val (div_a_eff),
        .wrap       (pre_wrap)
    );

    scl_div_stage #(.W(B_W)) u_tick_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (running),
        .step       (pre_wrap),
        .reload_val (div_b_eff),
        .wrap       (tick)
    );

    scl_frame_fsm #(.FRAME_TICKS(FRAME_TICKS)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .tick       (tick),
        .running    (running),
        .scl_level  (scl_level),
        .rise_stb   (rise_stb),
        .sample_stb (sample_stb),
        .fall_stb   (fall_stb),
        .drive_stb  (drive_stb)
    );

    initial begin
        a_r3_ctrl_width: assert (CTRL_W == 16);
    end

    // R1 / R9: once enable has been seen low, the line is released and quiet
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> (scl_level && !rise_stb && !fall_stb && !drive_stb && !sample_stb));
    // R8: the frozen divisors do not move while running
    a_r8_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running)) |-> ($stable(div_a_q) && $stable(div_b_q)));
    // R10: strobes are mutually exclusive
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_stb, fall_stb, drive_stb, sample_stb}));
endmodule

// File: tb/tb_scl_rate_gen.sv
`timescale 1ns/1ps
module tb_scl_rate_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] ctrl_word = '0;
    logic        scl_level, rise_stb, sample_stb, fall_stb, drive_stb;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    scl_rate_gen dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ctrl_word(ctrl_word),
        .scl_level(scl_level), .rise_stb(rise_stb), .sample_stb(sample_stb),
        .fall_stb(fall_stb), .drive_stb(drive_stb)
    );

    function automatic logic [15:0] mk_ctrl(int a, int b, int low);
        return {a[1:0], b[5:0], low[7:0]};
    endfunction

    task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: {scl,rise,fall,drive,sample} act=%b exp=%b at %0t",
                     req, act, exp, $time);
        end
    endtask

    // Start the generator with 'cfg', optionally rewrite ctrl at cycle midk,
    // compare every cycle with the timing for divisors a,b, then stop it.
    task automatic run_case(string req, int a, int b, logic [15:0] cfg,
                            int ncyc, int midk, logic [15:0] midcfg);
        int p = (a + 1) * (b + 1);
        @(negedge clk);
        ctrl_word = cfg;
        enable    = 1'b1;
        for (int k = 0; k < ncyc; k++) begin
            int  ph;
            bit  edge_k;
            logic [4:0] exp;
            @(negedge clk);
            ph     = (k / p) % 22;
            edge_k = (k % p) == 0;
            exp = {ph >= 11,
                   edge_k && ph == 11,
                   edge_k && ph == 0 && k != 0,
                   edge_k && ph == 5,
                   edge_k && ph == 16};
            chk(req, {scl_level, rise_stb, fall_stb, drive_stb, sample_stb}, exp);
            if ($countones({rise_stb, fall_stb, drive_stb, sample_stb}) > 1)
                chk("R10", 5'b1, 5'b0);
            if (k == midk) ctrl_word = midcfg;
        end
        enable = 1'b0;
        @(negedge clk);
        // R9: released one cycle after enable is seen low
        chk("R9", {scl_level, rise_stb, fall_stb, drive_stb, sample_stb}, 5'b10000);
    endtask

    task automatic test_reset;
        // R1: idle state after reset
        chk("R1", {scl_level, rise_stb, fall_stb, drive_stb, sample_stb}, 5'b10000);
        ctrl_word = 16'hFFFF;
        repeat (5) @(negedge clk);
        chk("R1", {scl_level, rise_stb, fall_stb, drive_stb, sample_stb}, 5'b10000);
    endtask

    task automatic test_fastest;   // R2 R3 R4 R5 R6 R7 with P = 1
        run_case("R4 R5 R6 R7 fastest", 0, 0, mk_ctrl(0, 0, 0), 22 * 3 + 4, -1, '0);
    endtask

    task automatic test_mixed;     // R2 R3 with A=1, B=2
        run_case("R2 R3 mixed", 1, 2, mk_ctrl(1, 2, 0), 6 * 22 * 2 + 3, -1, '0);
    endtask

    task automatic test_prescale_only;  // R2 alone, B=0
        run_case("R2 prescale", 3, 0, mk_ctrl(3, 0, 0), 4 * 22 * 2, -1, '0);
    endtask

    task automatic test_slowest;   // R3 with product 256
        run_case("R3 slowest", 3, 63, mk_ctrl(3, 63, 0), 256 * 22 + 300, -1, '0);
    endtask

    task automatic test_midrun_change;  // R8
        run_case("R8 frozen", 2, 4, mk_ctrl(2, 4, 0), 15 * 22 * 2, 40, mk_ctrl(0, 1, 8'h55));
    endtask

    task automatic test_low_bits;  // R11
        run_case("R11 low bits", 1, 1, mk_ctrl(1, 1, 8'hA7), 4 * 22 * 2, 10, mk_ctrl(1, 1, 8'h3C));
    endtask

    task automatic test_restart;   // R9: stop mid-frame, restart from slot 0
        run_case("R9 before stop", 1, 3, mk_ctrl(1, 3, 0), 8 * 13 + 3, -1, '0);
        run_case("R9 restart", 0, 2, mk_ctrl(0, 2, 0), 3 * 22 * 2, -1, '0);
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: act=timeout exp=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_fastest();
        test_mixed();
        test_prescale_only();
        test_midrun_change();
        test_low_bits();
        test_restart();
        test_slowest();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule